// File: doc/BRIEF.md
# Two-Line Open-Drain Pin Control Register

This block is a single memory-mapped control word that lets software bit-bang a two-wire bus over two bidirectional pins: a clock line and a data line. Each line has a direction field and an output value field. Each of those fields has its own write-enable mask bit in the same write word, so one write can change one field of one line and leave every other field alone. Bus timing comes entirely from software, which moves the lines through a series of such writes.

The pads are open-drain. A line is pulled low only when its direction is output and its stored value is 0. A line goes high when software sets its direction to input: the pad is released and the external pull-up raises it. Each pin level passes through a two-flop synchronizer and can then be read back in the same word. Two pull-up-disable bits, one per line, are ordinary read/write bits. Software preserves them by writing back the value it last read.

Top module: `pin_pair_reg`

Word layout (bit positions; every bit not listed reads 0 and is ignored on writes). Clock line base = 0, data line base = 8. At base+0 dir-mask, base+1 dir (1 = output), base+2 value-mask, base+3 value, base+4 input (read-only). Bit 16 = clock pull-up disable, bit 17 = data pull-up disable.

## Requirements
- R1: A line's direction field (base+1) takes the written value only when the direction-mask bit (base+0) is 1 in the same write; otherwise it keeps its value.
- R2: A line's value field (base+3) takes the written value only when the value-mask bit (base+2) is 1 in the same write; otherwise it keeps its value.
- R3: A write with a line's mask bits clear leaves that line's fields and pad unchanged, whatever happens to the other line.
- R4: A line's pull-low output is 1 exactly when its direction is output (1) and its value is 0, from the clock edge that stores the write.
- R5: A line whose direction is input (0) is never pulled low, whatever its stored value.
- R6: The input bit (base+4) shows the pin level sampled two clock edges earlier; writes to that bit have no effect.
- R7: The pull-up-disable bits (16, 17) take the written value on every write, drive the matching pull-up-off outputs and read back unchanged.
- R8: After reset both directions are input, both values are 0, both pull-up disables are 0, the input bits read 0 and neither pull-low output is set.
- R9: Read data returns the stored direction, value and pull-up-disable fields at their positions, with the mask bits and unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word (masks, fields, pull-up disables) |
| rd_data | output | 32 | Read word (fields, synchronized inputs) |
| ck_pin_in | input | 1 | Clock pin level from the pad |
| dt_pin_in | input | 1 | Data pin level from the pad |
| ck_pull_low | output | 1 | Clock pad driver enable (drives 0) |
| dt_pull_low | output | 1 | Data pad driver enable (drives 0) |
| ck_pullup_off | output | 1 | Clock pad pull-up disable |
| dt_pullup_off | output | 1 | Data pad pull-up disable |

## Verification
A register write and a pin edge can fall in the same cycle. A write can also update one line while its masks leave the other line alone. The bench changes a pin at the same edge at which a write flips that line's direction. It then checks that the new direction shows up one edge later, and that the input bit changes only after the second edge and not before. A sweep of all 1024 combinations of the ten writable bits, applied in sequence, makes both lines' fields change and hold in the same write. Every output and readback is compared with an arithmetic model in the bench.

// File: rtl/pinreg_pkg.sv
package pinreg_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_LINES  = 2;
  localparam int LINE_STEP  = 8;
  localparam int OFS_DMASK  = 0;
  localparam int OFS_DIR    = 1;
  localparam int OFS_VMASK  = 2;
  localparam int OFS_VAL    = 3;
  localparam int OFS_IN     = 4;
  localparam int PU_BASE    = 16;

  typedef struct packed {
    logic dir_out;
    logic val;
  } line_state_t;
endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/line_ctl.sv
module line_ctl
  import pinreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_nib,
  input  logic        pin_in,
  output line_state_t st,
  output logic        pin_sync,
  output logic        pull_low
);
  line_state_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (wr_en) begin
      if (wr_nib[OFS_DMASK]) st_q.dir_out <= wr_nib[OFS_DIR];
      if (wr_nib[OFS_VMASK]) st_q.val     <= wr_nib[OFS_VAL];
    end
  end

  in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign st       = st_q;
  assign pull_low = st_q.dir_out & ~st_q.val;

  assert_hold_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_nib[OFS_DMASK]) |=> $stable(st_q.dir_out));
  assert_take_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_nib[OFS_DMASK]) |=> st_q.dir_out == $past(wr_nib[OFS_DIR]));
  assert_hold_val_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_nib[OFS_VMASK]) |=> $stable(st_q.val));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_nib[OFS_DMASK] && !wr_nib[OFS_DIR]) |=> !pull_low);
endmodule

// File: rtl/pin_pair_reg.sv
module pin_pair_reg
  import pinreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              ck_pin_in,
  input  logic              dt_pin_in,
  output logic              ck_pull_low,
  output logic              dt_pull_low,
  output logic              ck_pullup_off,
  output logic              dt_pullup_off
);
  logic [NUM_LINES-1:0] pins, synced, pulls;
  line_state_t          st [NUM_LINES];
  logic [NUM_LINES-1:0] pu_q;

  assign pins = {dt_pin_in, ck_pin_in};

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      line_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_nib(wr_data[l*LINE_STEP +: 4]),
        .pin_in(pins[l]), .st(st[l]),
        .pin_sync(synced[l]), .pull_low(pulls[l])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     pu_q <= '0;
    else if (wr_en) pu_q <= wr_data[PU_BASE +: NUM_LINES];

  always_comb begin
    rd_data = '0;
    for (int l = 0; l < NUM_LINES; l++) begin
      rd_data[l*LINE_STEP + OFS_DIR] = st[l].dir_out;
      rd_data[l*LINE_STEP + OFS_VAL] = st[l].val;
      rd_data[l*LINE_STEP + OFS_IN]  = synced[l];
    end
    rd_data[PU_BASE +: NUM_LINES] = pu_q;
  end

  assign ck_pull_low   = pulls[0];
  assign dt_pull_low   = pulls[1];
  assign ck_pullup_off = pu_q[0];
  assign dt_pullup_off = pu_q[1];

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  assert_pullup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> {dt_pullup_off, ck_pullup_off} == $past(wr_data[PU_BASE +: 2]));
  assert_sync_ck_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && SYNC_STAGES == 2) |-> rd_data[OFS_IN] == $past(ck_pin_in, 2));
  assert_pull_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ck_pull_low |-> (rd_data[OFS_DIR] && !rd_data[OFS_VAL]));
endmodule

// File: tb/test_pin_pair_reg.sv
module test_pin_pair_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ck_pin_in = 1'b0, dt_pin_in = 1'b0;
  logic        ck_pull_low, dt_pull_low, ck_pullup_off, dt_pullup_off;

  int checks = 0, errors = 0;
  logic [1:0] m_dir = '0, m_val = '0, m_pu = '0, m_in = '0;

  always #4 clk = ~clk;

  pin_pair_reg i_pin_pair_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ck_pin_in(ck_pin_in), .dt_pin_in(dt_pin_in),
    .ck_pull_low(ck_pull_low), .dt_pull_low(dt_pull_low),
    .ck_pullup_off(ck_pullup_off), .dt_pullup_off(dt_pullup_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int l = 0; l < 2; l++) begin
      w[l*8+1] = m_dir[l];
      w[l*8+3] = m_val[l];
      w[l*8+4] = m_in[l];
    end
    w[17:16] = m_pu;
    return w;
  endfunction

  task automatic check_all(input string req);
    chk({req, " readback"}, rd_data, exp_word());
    chk({req, " pull-low"}, {30'd0, dt_pull_low, ck_pull_low}, {30'd0, m_dir & ~m_val});
    chk({req, " pull-up off"}, {30'd0, dt_pullup_off, ck_pullup_off}, {30'd0, m_pu});
  endtask

  // write at a negedge; results checked at the next negedge, one posedge later
  task automatic do_write(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    for (int l = 0; l < 2; l++) begin
      if (w[l*8+0]) m_dir[l] = w[l*8+1];
      if (w[l*8+2]) m_val[l] = w[l*8+3];
    end
    m_pu = w[17:16];
  endtask

  function automatic logic [31:0] pack10(input int i);
    logic [31:0] w = '0;
    w[3:0]   = i[3:0];
    w[11:8]  = i[7:4];
    w[17:16] = i[9:8];
    return w;
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R8 after release");

    // R1 R2 R3 R4 R5 R7 R9: full sweep of all writable-bit combinations
    for (int i = 0; i < 1024; i++) begin
      do_write(pack10(i));
      check_all("R1 R2 R3 R4 R5 R7 R9 sweep");
    end
    // same sweep with stray bits set: input bits and unused bits have no effect (R6, R9)
    for (int i = 0; i < 1024; i += 37) begin
      do_write(pack10(i) | 32'hFFFC_E0F0 | 32'h0000_1010);
      check_all("R6 R9 stray bits ignored");
    end

    // R5: value 1 with output direction releases; value 0 with input direction releases
    do_write(32'h0000_0F0F);          // both: dir=out, val=1
    check_all("R5 out high released");
    do_write(32'h0000_0404);          // val=0 only, dir stays out
    check_all("R4 pulled low");
    do_write(32'h0000_0101);          // dir=in, val stays 0
    check_all("R5 input released");

    // R6: pin edge visible after exactly two edges
    @(negedge clk);
    ck_pin_in = 1'b1; dt_pin_in = 1'b1;
    @(negedge clk);
    chk("R6 one edge", {30'd0, rd_data[12], rd_data[4]}, 32'd0);
    @(negedge clk);
    m_in = 2'b11;
    chk("R6 two edges", {30'd0, rd_data[12], rd_data[4]}, 32'd3);

    // R6 + R1 coincident: pin change at the same edge as a direction write
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0007;   // clock line: dir=out, val=0
    ck_pin_in = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    m_dir[0] = 1'b1; m_val[0] = 1'b0; m_pu = 2'b00;
    check_all("R1 R6 coincident (input still old)");
    @(negedge clk);
    m_in[0] = 1'b0;
    check_all("R6 coincident (input updated)");

    // R3: data-line-only write leaves clock line intact
    do_write(32'h0003_0300);
    check_all("R3 other line untouched");

    // R8: reset in mid-operation
    @(negedge clk);
    rst_n = 1'b0;
    m_dir = '0; m_val = '0; m_pu = '0; m_in = '0;
    @(negedge clk);
    check_all("R8 second reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule